// File: doc/BRIEF.md
# Bidirectional Mailbox Register Bank

A bank of 32-bit mailbox registers that passes short messages between a host side and a local side. Inbound boxes are filled by the host and read by the local side. Outbound boxes are filled by the local side and read by the host. Each side has its own port with per-byte enables, so byte, halfword and word transfers all use the same path. Reads on both ports are registered and return one clock edge after the request.

Local accesses can produce host interrupt requests. An external configuration names one box and one byte lane for outbound writes, and a separate box and lane for inbound reads. When a local access touches that lane of that box, a sticky pending bit is set. The bit stays set until a host-side clear pulse. The two pending bits are ORed onto a single interrupt line.

Each box also has an occupancy flag. A flag is set when the producing side writes the box and cleared when the consuming side reads it. Mailbox contents are not initialised by reset.

Top module: `mailbox_bank`

## Requirements
- R1: `loc_addr[4]` selects the region (0 = inbound, 1 = outbound) and `loc_addr[3:2]` selects the box (0..3 for boxes 1..4). `loc_addr[1:0]` is ignored. A local read loads `loc_rdata` on the next clock edge, and `loc_rdata` holds its value in cycles with no local read.
- R2: A local write to an outbound box updates only the bytes whose `loc_be` bit is set, where bit i covers data bits 8i+7..8i. A local read of an outbound box returns its current contents.
- R3: A local write to any inbound offset changes no mailbox content, no occupancy flag and no pending bit.
- R4: A host write updates the enabled bytes of inbound box `host_box`. A host read returns outbound box `host_box` on `host_rdata` on the next edge.
- R5: A read in the same cycle as a write to the same box returns the contents from before that write.
- R6: When `cfg_wr_en` is high, a local write to outbound box `cfg_wr_box` with `loc_be[cfg_wr_byte]` set raises `wr_pend` on the next edge. The bit stays high until `clr_wr`. If a setting event and `clr_wr` arrive in the same cycle, the set wins.
- R7: When `cfg_rd_en` is high, a local read of inbound box `cfg_rd_box` with `loc_be[cfg_rd_byte]` set raises `rd_pend` on the next edge. The bit stays high until `clr_rd`, and the set wins over a simultaneous clear.
- R8: `irq` is high exactly when `wr_pend` or `rd_pend` is high.
- R9: `out_full[b]` is set by any local write to outbound box b and cleared by a host read of it. `in_full[b]` is set by a host write to inbound box b and cleared by a local read of it. A set wins over a clear in the same cycle.
- R10: After reset, the occupancy flags, the pending bits, `irq`, `loc_rdata` and `host_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| loc_sel | input | 1 | Local access strobe |
| loc_wr | input | 1 | Local write (1) or read (0) |
| loc_addr | input | 5 | Local byte offset |
| loc_be | input | 4 | Local byte enables |
| loc_wdata | input | 32 | Local write data |
| loc_rdata | output | 32 | Local read data, registered |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | Host write (1) or read (0) |
| host_box | input | 2 | Host box index |
| host_be | input | 4 | Host byte enables |
| host_wdata | input | 32 | Host write data to inbound box |
| host_rdata | output | 32 | Host read data from outbound box, registered |
| cfg_wr_en | input | 1 | Enable interrupt on outbound write |
| cfg_wr_box | input | 2 | Outbound box watched |
| cfg_wr_byte | input | 2 | Byte lane watched on outbound write |
| cfg_rd_en | input | 1 | Enable interrupt on inbound read |
| cfg_rd_box | input | 2 | Inbound box watched |
| cfg_rd_byte | input | 2 | Byte lane watched on inbound read |
| clr_wr | input | 1 | Clear pulse for write-event pending bit |
| clr_rd | input | 1 | Clear pulse for read-event pending bit |
| in_full | output | 4 | Inbound box occupancy flags |
| out_full | output | 4 | Outbound box occupancy flags |
| wr_pend | output | 1 | Write-event pending |
| rd_pend | output | 1 | Read-event pending |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default four boxes of 32 bits. At that size each box index and byte lane is a two-bit field, so random stimulus often lands on the configured interrupt box and lane. The same size also makes collisions frequent: simultaneous host and local accesses to one box, and set/clear races on the flags. The reference model tracks which bytes have been written, so bytes that have never been written are excluded from comparison.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int unsigned LANE_W = 8;

    typedef struct packed {
        logic wr_pend;
        logic rd_pend;
    } irq_st_t;
endpackage

// File: rtl/mbx_store.sv
module mbx_store #(
    parameter int unsigned NUM_BOX = 4,
    parameter int unsigned DW      = 32,
    localparam int unsigned NB     = DW / mbx_pkg::LANE_W,
    localparam int unsigned BW     = $clog2(NUM_BOX),
    localparam int unsigned AW     = BW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          loc_sel,
    input  logic          loc_wr,
    input  logic [AW-1:0] loc_addr,
    input  logic [NB-1:0] loc_be,
    input  logic [DW-1:0] loc_wdata,
    output logic [DW-1:0] loc_rdata,
    input  logic          host_sel,
    input  logic          host_wr,
    input  logic [BW-1:0] host_box,
    input  logic [NB-1:0] host_be,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata
);
    localparam int unsigned LW = mbx_pkg::LANE_W;

    typedef logic [NUM_BOX-1:0][DW-1:0] bank_t;
    typedef struct packed {
        bank_t inb;
        bank_t outb;
    } data_t;
    typedef struct packed {
        logic [DW-1:0] lrd;
        logic [DW-1:0] hrd;
    } rd_t;

    data_t         dat_d, dat_q;
    rd_t           rd_d, rd_q;
    logic [BW-1:0] loc_box;
    logic          loc_out;

    assign loc_box = loc_addr[AW-2:2];
    assign loc_out = loc_addr[AW-1];

    always_comb begin
        dat_d = dat_q;
        rd_d  = rd_q;
        if (loc_sel && !loc_wr) begin
            rd_d.lrd = loc_out ? dat_q.outb[loc_box] : dat_q.inb[loc_box];
        end
        if (host_sel && !host_wr) begin
            rd_d.hrd = dat_q.outb[host_box];
        end
        for (int l = 0; l < NB; l++) begin
            if (loc_sel && loc_wr && loc_out && loc_be[l]) begin
                dat_d.outb[loc_box][l*LW +: LW] = loc_wdata[l*LW +: LW];
            end
            if (host_sel && host_wr && host_be[l]) begin
                dat_d.inb[host_box][l*LW +: LW] = host_wdata[l*LW +: LW];
            end
        end
    end

    always_ff @(posedge clk) begin
        dat_q <= dat_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign loc_rdata  = rd_q.lrd;
    assign host_rdata = rd_q.hrd;

    AST_LRD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_sel && !loc_wr) |=> $stable(loc_rdata)); // R1
    AST_IN_LOCAL_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_sel && loc_wr && !loc_out && !(host_sel && host_wr))
        |=> (dat_q.inb === $past(dat_q.inb))); // R3
    AST_OUT_NO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_sel && loc_wr && loc_out && (loc_be == '0))
        |=> (dat_q.outb === $past(dat_q.outb))); // R2
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags #(
    parameter int unsigned NUM_BOX = 4,
    localparam int unsigned BW     = $clog2(NUM_BOX),
    localparam int unsigned AW     = BW + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               loc_sel,
    input  logic               loc_wr,
    input  logic [AW-1:0]      loc_addr,
    input  logic               host_sel,
    input  logic               host_wr,
    input  logic [BW-1:0]      host_box,
    output logic [NUM_BOX-1:0] in_full,
    output logic [NUM_BOX-1:0] out_full
);
    typedef struct packed {
        logic [NUM_BOX-1:0] inf;
        logic [NUM_BOX-1:0] outf;
    } flag_t;

    flag_t         fl_d, fl_q;
    logic [BW-1:0] loc_box;
    logic          loc_out;

    assign loc_box = loc_addr[AW-2:2];
    assign loc_out = loc_addr[AW-1];

    always_comb begin
        fl_d = fl_q;
        if (loc_sel && !loc_wr && !loc_out) fl_d.inf[loc_box]   = 1'b0;
        if (host_sel && host_wr)            fl_d.inf[host_box]  = 1'b1;
        if (host_sel && !host_wr)           fl_d.outf[host_box] = 1'b0;
        if (loc_sel && loc_wr && loc_out)   fl_d.outf[loc_box]  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign in_full  = fl_q.inf;
    assign out_full = fl_q.outf;

    AST_OUTF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_sel && loc_wr && loc_out) |=> out_full[$past(loc_box)]); // R9
    AST_INF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && host_wr) |=> in_full[$past(host_box)]); // R9
    AST_INF_LOCAL_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_sel && loc_wr && !loc_out && !(host_sel && host_wr)) |=> $stable(in_full)); // R3
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
    parameter int unsigned NUM_BOX = 4,
    parameter int unsigned NB      = 4,
    localparam int unsigned BW     = $clog2(NUM_BOX),
    localparam int unsigned LB     = $clog2(NB),
    localparam int unsigned AW     = BW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          loc_sel,
    input  logic          loc_wr,
    input  logic [AW-1:0] loc_addr,
    input  logic [NB-1:0] loc_be,
    input  logic          cfg_wr_en,
    input  logic [BW-1:0] cfg_wr_box,
    input  logic [LB-1:0] cfg_wr_byte,
    input  logic          cfg_rd_en,
    input  logic [BW-1:0] cfg_rd_box,
    input  logic [LB-1:0] cfg_rd_byte,
    input  logic          clr_wr,
    input  logic          clr_rd,
    output logic          wr_pend,
    output logic          rd_pend,
    output logic          irq
);
    mbx_pkg::irq_st_t st_d, st_q;
    logic [BW-1:0]    loc_box;
    logic             loc_out;
    logic             wr_hit, rd_hit;

    assign loc_box = loc_addr[AW-2:2];
    assign loc_out = loc_addr[AW-1];

    always_comb begin
        wr_hit = cfg_wr_en && loc_sel && loc_wr && loc_out &&
                 (loc_box == cfg_wr_box) && loc_be[cfg_wr_byte];
        rd_hit = cfg_rd_en && loc_sel && !loc_wr && !loc_out &&
                 (loc_box == cfg_rd_box) && loc_be[cfg_rd_byte];
        st_d = st_q;
        if (clr_wr) st_d.wr_pend = 1'b0;
        if (wr_hit) st_d.wr_pend = 1'b1;
        if (clr_rd) st_d.rd_pend = 1'b0;
        if (rd_hit) st_d.rd_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_pend = st_q.wr_pend;
    assign rd_pend = st_q.rd_pend;
    assign irq     = st_q.wr_pend | st_q.rd_pend;

    AST_WR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pend && !clr_wr) |=> wr_pend); // R6
    AST_RD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pend && !clr_rd) |=> rd_pend); // R7
    AST_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_pend && !(loc_sel && loc_wr && loc_out)) |=> !wr_pend); // R6
    AST_IN_WR_NOIRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_sel && loc_wr && !loc_out && !rd_pend) |=> !rd_pend); // R3
endmodule

// File: rtl/mailbox_bank.sv
module mailbox_bank #(
    parameter int unsigned NUM_BOX = 4,
    parameter int unsigned DW      = 32,
    localparam int unsigned NB     = DW / mbx_pkg::LANE_W,
    localparam int unsigned BW     = $clog2(NUM_BOX),
    localparam int unsigned LB     = $clog2(NB),
    localparam int unsigned AW     = BW + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               loc_sel,
    input  logic               loc_wr,
    input  logic [AW-1:0]      loc_addr,
    input  logic [NB-1:0]      loc_be,
    input  logic [DW-1:0]      loc_wdata,
    output logic [DW-1:0]      loc_rdata,
    input  logic               host_sel,
    input  logic               host_wr,
    input  logic [BW-1:0]      host_box,
    input  logic [NB-1:0]      host_be,
    input  logic [DW-1:0]      host_wdata,
    output logic [DW-1:0]      host_rdata,
    input  logic               cfg_wr_en,
    input  logic [BW-1:0]      cfg_wr_box,
    input  logic [LB-1:0]      cfg_wr_byte,
    input  logic               cfg_rd_en,
    input  logic [BW-1:0]      cfg_rd_box,
    input  logic [LB-1:0]      cfg_rd_byte,
    input  logic               clr_wr,
    input  logic               clr_rd,
    output logic [NUM_BOX-1:0] in_full,
    output logic [NUM_BOX-1:0] out_full,
    output logic               wr_pend,
    output logic               rd_pend,
    output logic               irq
);
    mbx_store #(.NUM_BOX(NUM_BOX), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .loc_sel(loc_sel), .loc_wr(loc_wr), .loc_addr(loc_addr),
        .loc_be(loc_be), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .host_sel(host_sel), .host_wr(host_wr), .host_box(host_box),
        .host_be(host_be), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    mbx_flags #(.NUM_BOX(NUM_BOX)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .loc_sel(loc_sel), .loc_wr(loc_wr), .loc_addr(loc_addr),
        .host_sel(host_sel), .host_wr(host_wr), .host_box(host_box),
        .in_full(in_full), .out_full(out_full)
    );

    mbx_irq #(.NUM_BOX(NUM_BOX), .NB(NB)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .loc_sel(loc_sel), .loc_wr(loc_wr), .loc_addr(loc_addr), .loc_be(loc_be),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_box(cfg_wr_box), .cfg_wr_byte(cfg_wr_byte),
        .cfg_rd_en(cfg_rd_en), .cfg_rd_box(cfg_rd_box), .cfg_rd_byte(cfg_rd_byte),
        .clr_wr(clr_wr), .clr_rd(clr_rd),
        .wr_pend(wr_pend), .rd_pend(rd_pend), .irq(irq)
    );
endmodule

// File: tb/mailbox_bank_tb.sv
module mailbox_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        loc_sel = 0, loc_wr = 0;
    logic [4:0]  loc_addr = '0;
    logic [3:0]  loc_be = '0;
    logic [31:0] loc_wdata = '0;
    logic [31:0] loc_rdata;
    logic        host_sel = 0, host_wr = 0;
    logic [1:0]  host_box = '0;
    logic [3:0]  host_be = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        cfg_wr_en = 0, cfg_rd_en = 0;
    logic [1:0]  cfg_wr_box = '0, cfg_wr_byte = '0, cfg_rd_box = '0, cfg_rd_byte = '0;
    logic        clr_wr = 0, clr_rd = 0;
    logic [3:0]  in_full, out_full;
    logic        wr_pend, rd_pend, irq;

    int n_vec = 0;
    int n_bad = 0;
    string note = "R1 R2 R4";

    always #10 clk = ~clk;

    mailbox_bank u_dut (
        .clk(clk), .rst_n(rst_n),
        .loc_sel(loc_sel), .loc_wr(loc_wr), .loc_addr(loc_addr), .loc_be(loc_be),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .host_sel(host_sel), .host_wr(host_wr), .host_box(host_box), .host_be(host_be),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_box(cfg_wr_box), .cfg_wr_byte(cfg_wr_byte),
        .cfg_rd_en(cfg_rd_en), .cfg_rd_box(cfg_rd_box), .cfg_rd_byte(cfg_rd_byte),
        .clr_wr(clr_wr), .clr_rd(clr_rd),
        .in_full(in_full), .out_full(out_full),
        .wr_pend(wr_pend), .rd_pend(rd_pend), .irq(irq)
    );

    // behavioural reference model
    logic [31:0] m_in [4];
    logic [31:0] m_out [4];
    logic [3:0]  k_in [4];
    logic [3:0]  k_out [4];
    logic [3:0]  m_inf = '0, m_outf = '0;
    logic        m_wp = 0, m_rp = 0;
    logic [31:0] e_lrd = '0, e_hrd = '0;
    logic [3:0]  e_lmask = '0, e_hmask = '0;
    logic        lrd_chk = 0, hrd_chk = 0;

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_in[i] = '0; m_out[i] = '0; k_in[i] = '0; k_out[i] = '0;
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            int lb;
            lb = int'(loc_addr[3:2]);
            lrd_chk = 0; hrd_chk = 0;
            if (loc_sel && !loc_wr) begin
                e_lrd   = loc_addr[4] ? m_out[lb] : m_in[lb];
                e_lmask = (loc_addr[4] ? k_out[lb] : k_in[lb]) & loc_be;
                lrd_chk = 1;
                if (!loc_addr[4]) m_inf[lb] = 1'b0;
            end
            if (host_sel && !host_wr) begin
                e_hrd   = m_out[host_box];
                e_hmask = k_out[host_box] & host_be;
                hrd_chk = 1;
                m_outf[host_box] = 1'b0;
            end
            if (host_sel && host_wr) m_inf[host_box] = 1'b1;
            if (loc_sel && loc_wr && loc_addr[4]) m_outf[lb] = 1'b1;
            if (clr_wr) m_wp = 0;
            if (clr_rd) m_rp = 0;
            if (cfg_wr_en && loc_sel && loc_wr && loc_addr[4] && lb == int'(cfg_wr_box)
                && loc_be[cfg_wr_byte]) m_wp = 1;
            if (cfg_rd_en && loc_sel && !loc_wr && !loc_addr[4] && lb == int'(cfg_rd_box)
                && loc_be[cfg_rd_byte]) m_rp = 1;
            for (int l = 0; l < 4; l++) begin
                if (loc_sel && loc_wr && loc_addr[4] && loc_be[l]) begin
                    m_out[lb][l*8 +: 8] = loc_wdata[l*8 +: 8];
                    k_out[lb][l] = 1'b1;
                end
                if (host_sel && host_wr && host_be[l]) begin
                    m_in[host_box][l*8 +: 8] = host_wdata[l*8 +: 8];
                    k_in[host_box][l] = 1'b1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp,
                       input logic [31:0] mask);
        n_vec++;
        if ((got & mask) !== (exp & mask)) begin
            n_bad++;
            $display("FAIL %s got %h expected %h (mask %h)", tag, got & mask, exp & mask, mask);
        end
    endtask

    function automatic logic [31:0] lanes(input logic [3:0] m);
        return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
    endfunction

    task automatic compare_all();
        if (lrd_chk) chk({note, " loc_rdata"}, loc_rdata, e_lrd, lanes(e_lmask));
        if (hrd_chk) chk("R4 R5 host_rdata", host_rdata, e_hrd, lanes(e_hmask));
        chk("R9 in_full", {28'd0, in_full}, {28'd0, m_inf}, 32'hF);
        chk("R9 out_full", {28'd0, out_full}, {28'd0, m_outf}, 32'hF);
        chk("R6 wr_pend", {31'd0, wr_pend}, {31'd0, m_wp}, 32'h1);
        chk("R7 rd_pend", {31'd0, rd_pend}, {31'd0, m_rp}, 32'h1);
        chk("R8 irq", {31'd0, irq}, {31'd0, m_wp | m_rp}, 32'h1);
    endtask

    task automatic step(input logic ls, input logic lw, input logic [4:0] la,
                        input logic [3:0] lbe, input logic [31:0] lwd,
                        input logic hs, input logic hw, input logic [1:0] hb,
                        input logic [3:0] hbe, input logic [31:0] hwd,
                        input logic cw, input logic cr);
        @(negedge clk);
        compare_all();
        loc_sel = ls; loc_wr = lw; loc_addr = la; loc_be = lbe; loc_wdata = lwd;
        host_sel = hs; host_wr = hw; host_box = hb; host_be = hbe; host_wdata = hwd;
        clr_wr = cw; clr_rd = cr;
    endtask

    task automatic lrd(input logic [4:0] a, input logic [3:0] be);
        step(1, 0, a, be, '0, 0, 0, '0, '0, '0, 0, 0);
    endtask
    task automatic lwr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
        step(1, 1, a, be, d, 0, 0, '0, '0, '0, 0, 0);
    endtask
    task automatic hwr(input logic [1:0] b, input logic [3:0] be, input logic [31:0] d);
        step(0, 0, '0, '0, '0, 1, 1, b, be, d, 0, 0);
    endtask
    task automatic hrd(input logic [1:0] b);
        step(0, 0, '0, '0, '0, 1, 0, b, 4'hF, '0, 0, 0);
    endtask
    task automatic idle();
        step(0, 0, '0, '0, '0, 0, 0, '0, '0, '0, 0, 0);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 loc_rdata", loc_rdata, '0, '1);
        chk("R10 host_rdata", host_rdata, '0, '1);
        chk("R10 flags", {24'd0, in_full, out_full}, '0, '1);
        chk("R10 pend", {29'd0, wr_pend, rd_pend, irq}, '0, '1);
        rst_n = 1'b1;
        cfg_wr_en = 1; cfg_wr_box = 2'd2; cfg_wr_byte = 2'd1;
        cfg_rd_en = 1; cfg_rd_box = 2'd0; cfg_rd_byte = 2'd3;

        note = "R4 R1";
        hwr(2'd0, 4'hF, 32'hA1B2C3D4);
        note = "R7 R1";
        lrd(5'h00, 4'b0001);          // byte 3 not touched: no event
        lrd(5'h03, 4'b1000);          // low address bits ignored, event fires
        note = "R3";
        lwr(5'h00, 4'hF, 32'h11111111); // ignored
        lwr(5'h04, 4'hF, 32'h22222222); // ignored
        lrd(5'h00, 4'hF);
        note = "R6 R2";
        lwr(5'h18, 4'b0001, 32'h000000EE); // wrong lane, no event
        lrd(5'h18, 4'hF);
        lwr(5'h18, 4'b0010, 32'h0000DD00); // event
        lrd(5'h18, 4'hF);
        hrd(2'd2);
        // R6: clear together with a new hit, set wins
        step(1, 1, 5'h18, 4'b0010, 32'h00007700, 0, 0, '0, '0, '0, 1, 0);
        step(0, 0, '0, '0, '0, 0, 0, '0, '0, '0, 1, 1); // clear both
        idle();
        note = "R2";
        lwr(5'h1C, 4'b0011, 32'h0000BEEF);
        lwr(5'h1C, 4'b1100, 32'hCAFE0000);
        lrd(5'h1C, 4'b1100);
        lrd(5'h1C, 4'hF);
        note = "R5";
        hwr(2'd1, 4'hF, 32'h01020304);
        // local read and host write of box 2 in the same cycle
        step(1, 0, 5'h04, 4'hF, '0, 1, 1, 2'd1, 4'hF, 32'h55667788, 0, 0);
        lrd(5'h04, 4'hF);
        // host read and local write of outbound box 4 in the same cycle
        step(1, 1, 5'h1C, 4'hF, 32'h9ABCDEF0, 1, 0, 2'd3, 4'hF, '0, 0, 0);
        hrd(2'd3);
        idle();

        note = "R1 R2 R4";
        for (int i = 0; i < 3000; i++) begin
            if (i % 200 == 0) begin
                cfg_wr_en = 1'($urandom); cfg_rd_en = 1'($urandom);
                cfg_wr_box = 2'($urandom); cfg_wr_byte = 2'($urandom);
                cfg_rd_box = 2'($urandom); cfg_rd_byte = 2'($urandom);
            end
            step(1'($urandom), 1'($urandom), 5'($urandom), 4'($urandom), $urandom,
                 1'($urandom), 1'($urandom), 2'($urandom), 4'($urandom), $urandom,
                 ($urandom % 8) == 0, ($urandom % 8) == 0);
        end
        idle();
        idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule